// File: doc/BRIEF.md
# Fault Confinement Error Counter Unit

This block holds the two fault-confinement counters of a serial bus node, one for transmit-side errors and one for receive-side errors. It sits beside a protocol controller that detects errors and recognises frame events; the controller raises single-cycle strobes, one per sampled bus bit, for each event that moves a counter. The unit weighs each event, applies the exception qualifiers, and reports both counts, the node's confinement state and an early warning of a heavily disturbed bus.

Three further mechanisms sit inside the block. It watches the bit stream after an error or overload flag and charges a penalty for long runs of dominant bits. It clamps the receive count when a frame is received cleanly. Once the node is bus off, it counts runs of recessive bits and returns the node to error active after enough of them. Frame decoding and error detection stay with the controller.

Top module: `fault_conf_counter`

## Requirements
- R1: After reset both counts are 0, the state is error active (state code 0) and the warning is low. The state is error passive (code 1) when either count is 128 or more, and error active again once both counts are 127 or less.
- R2: A receiver error strobe adds 1 to the receive count, unless the qualifier marking it as a bit error while the node sent an active error flag or overload flag is set, in which case the count does not change.
- R3: In the bits after a flag, the 14th consecutive dominant bit (active or overload flag context) or the 8th (passive flag context) adds 8, and each further 8 consecutive dominant bits add 8 again; the transmit count is charged when the node is transmitter, the receive count otherwise. A recessive bit ends the run.
- R4: An error flag sent as transmitter adds 8 to the transmit count; a dominant first bit after a flag adds 8 to the receive count; a bit error while sending an active error flag or overload flag adds 8 to the transmit count for a transmitter and to the receive count for a receiver.
- R5: The transmitter flag penalty is skipped when the stuff-during-arbitration qualifier is set, or when the acknowledgment qualifier is set while the node is error passive; the acknowledgment qualifier has no effect while error active.
- R6: A successful reception lowers the receive count by 1 when it is between 1 and 127, keeps 0 at 0, and sets a count above 127 to 127.
- R7: A successful transmission lowers the transmit count by 1 unless it is 0.
- R8: The receive count never exceeds 128.
- R9: The warning is high when either count is 96 or more.
- R10: The state is bus off (code 2) when the transmit count reaches 256 or more; while bus off, every strobe other than the recovery bit strobe leaves both counts unchanged.
- R11: A bus-off node returns to error active with both counts at 0 on the sampled recessive bit that completes its 128th run of 11 consecutive recessive bits; a dominant recovery bit restarts the current run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_tx_i | input | 1 | Node is transmitter of the current frame (1) or receiver (0) |
| rx_err_i | input | 1 | Receiver detected an error |
| rx_err_flag_bit_i | input | 1 | Qualifier: that error was a bit error while sending an active error flag or overload flag |
| tx_flag_i | input | 1 | Transmitter sends an error flag |
| exc_ack_i | input | 1 | Qualifier: acknowledgment error with no dominant bit seen during the passive flag |
| exc_arb_stuff_i | input | 1 | Qualifier: flag caused by a stuff error in arbitration on a recessive bit read dominant |
| flag_bit_err_i | input | 1 | Bit error while sending an active error flag or overload flag |
| first_dom_i | input | 1 | Receiver saw a dominant bit as first bit after its error flag |
| post_bit_i | input | 1 | A bit was sampled in the window after a flag |
| post_dom_i | input | 1 | That post-flag bit was dominant |
| post_pas_ctx_i | input | 1 | Post-flag window follows a passive error flag (1) or an active/overload flag (0) |
| tx_done_i | input | 1 | Successful transmission |
| rx_done_i | input | 1 | Successful reception |
| bus_bit_i | input | 1 | A bus bit was sampled during bus-off recovery |
| bus_rec_i | input | 1 | That recovery bit was recessive |
| tec_o | output | TEC_W | Transmit error count |
| rec_o | output | REC_W | Receive error count |
| state_o | output | 2 | Confinement state: 0 active, 1 passive, 2 bus off |
| warn_o | output | 1 | Heavy-disturbance warning |

## Verification
The bench builds the unit with its default parameters: 9-bit transmit count, 8-bit receive count, thresholds of 96, 128 and 256, and a recovery of 128 runs of 11 recessive bits. With these values the full walk from reset through warning, error passive and bus off, and the complete recovery of 1408 bit strobes, fits in a short run, so every threshold edge is hit at its exact count. The dominant-run penalties are checked one bit before and on the bit that charges them, in both flag contexts.

// File: rtl/fcec_pkg.sv
`timescale 1ns/1ps
package fcec_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PASSIVE = 2'd1,
        ST_BUSOFF  = 2'd2
    } conf_state_e;
endpackage

// File: rtl/fcec_dom_run.sv
`timescale 1ns/1ps
// Tracks consecutive dominant bits after a flag and pulses a penalty
// on the first threshold and on every REPEAT bits after it.
module fcec_dom_run #(
    parameter int FIRST_ACT = 14,
    parameter int FIRST_PAS = 8,
    parameter int REPEAT    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bit_stb,
    input  logic bit_dom,
    input  logic ctx_pas,
    output logic penalty
);
    localparam int FIRST_MAX = (FIRST_ACT > FIRST_PAS) ? FIRST_ACT : FIRST_PAS;
    localparam int RUN_W     = $clog2(FIRST_MAX + 1);
    localparam int REP_W     = (REPEAT > 1) ? $clog2(REPEAT) : 1;
    localparam logic [RUN_W-1:0] THR_ACT  = RUN_W'(FIRST_ACT);
    localparam logic [RUN_W-1:0] THR_PAS  = RUN_W'(FIRST_PAS);
    localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEAT - 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic [REP_W-1:0] rep;
    } run_t;

    run_t cur_q, nxt_d;
    logic [RUN_W-1:0] thr_d;

    always_comb begin
        nxt_d   = cur_q;
        penalty = 1'b0;
        thr_d   = ctx_pas ? THR_PAS : THR_ACT;
        if (clr) begin
            nxt_d = '0;
        end else if (bit_stb) begin
            if (!bit_dom) begin
                nxt_d = '0;
            end else if (cur_q.run < thr_d - 1'b1) begin
                nxt_d.run = cur_q.run + 1'b1;
            end else if (cur_q.run == thr_d - 1'b1) begin
                nxt_d.run = thr_d;
                nxt_d.rep = '0;
                penalty   = 1'b1;
            end else if (cur_q.rep == REP_LAST) begin
                nxt_d.rep = '0;
                penalty   = 1'b1;
            end else begin
                nxt_d.rep = cur_q.rep + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/fcec_recovery.sv
`timescale 1ns/1ps
// Counts runs of consecutive recessive bits while bus off.
module fcec_recovery #(
    parameter int BITS = 11,
    parameter int RUNS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_stb,
    input  logic bit_rec,
    output logic done
);
    localparam int BIT_W  = $clog2(BITS);
    localparam int RUNS_W = $clog2(RUNS);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BITS - 1);
    localparam logic [RUNS_W-1:0] LAST_RUN = RUNS_W'(RUNS - 1);

    typedef struct packed {
        logic [BIT_W-1:0]  bits;
        logic [RUNS_W-1:0] runs;
    } rcv_t;

    rcv_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        done  = 1'b0;
        if (!en) begin
            nxt_d = '0;
        end else if (bit_stb) begin
            if (!bit_rec) begin
                nxt_d.bits = '0;
            end else if (cur_q.bits == LAST_BIT) begin
                nxt_d.bits = '0;
                nxt_d.runs = cur_q.runs + 1'b1;
                done       = (cur_q.runs == LAST_RUN);
            end else begin
                nxt_d.bits = cur_q.bits + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/fault_conf_counter.sv
`timescale 1ns/1ps
module fault_conf_counter
    import fcec_pkg::*;
#(
    parameter int TEC_W      = 9,
    parameter int REC_W      = 8,
    parameter int PASS_LVL   = 128,
    parameter int BOFF_LVL   = 256,
    parameter int WARN_LVL   = 96,
    parameter int PENALTY    = 8,
    parameter int REC_RELOAD = 127,
    parameter int ACT_RUN    = 14,
    parameter int PAS_RUN    = 8,
    parameter int RPT_RUN    = 8,
    parameter int RCV_BITS   = 11,
    parameter int RCV_RUNS   = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_tx_i,
    input  logic             rx_err_i,
    input  logic             rx_err_flag_bit_i,
    input  logic             tx_flag_i,
    input  logic             exc_ack_i,
    input  logic             exc_arb_stuff_i,
    input  logic             flag_bit_err_i,
    input  logic             first_dom_i,
    input  logic             post_bit_i,
    input  logic             post_dom_i,
    input  logic             post_pas_ctx_i,
    input  logic             tx_done_i,
    input  logic             rx_done_i,
    input  logic             bus_bit_i,
    input  logic             bus_rec_i,
    output logic [TEC_W-1:0] tec_o,
    output logic [REC_W-1:0] rec_o,
    output logic [1:0]       state_o,
    output logic             warn_o
);
    // Sums are one bit wider than the counters.
    localparam logic [TEC_W:0]   T_PEN    = (TEC_W+1)'(PENALTY);
    localparam logic [TEC_W:0]   T_MAX    = (TEC_W+1)'((1 << TEC_W) - 1);
    localparam logic [TEC_W-1:0] T_PASS   = TEC_W'(PASS_LVL);
    localparam logic [TEC_W-1:0] T_BOFF   = TEC_W'(BOFF_LVL);
    localparam logic [TEC_W-1:0] T_WARN   = TEC_W'(WARN_LVL);
    localparam logic [REC_W:0]   R_PEN    = (REC_W+1)'(PENALTY);
    localparam logic [REC_W:0]   R_ONE    = (REC_W+1)'(1);
    localparam logic [REC_W:0]   R_CEIL   = (REC_W+1)'(PASS_LVL);
    localparam logic [REC_W-1:0] R_PASS   = REC_W'(PASS_LVL);
    localparam logic [REC_W-1:0] R_TOP    = REC_W'(PASS_LVL - 1);
    localparam logic [REC_W-1:0] R_RELOAD = REC_W'(REC_RELOAD);
    localparam logic [REC_W-1:0] R_WARN   = REC_W'(WARN_LVL);

    typedef struct packed {
        logic [TEC_W-1:0] tec;
        logic [REC_W-1:0] rec;
        conf_state_e      st;
        logic             warn;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic             live;
    logic             dom_pen;
    logic             recov_done;
    logic             tx_flag_counts;
    logic [TEC_W-1:0] tec_base;
    logic [TEC_W:0]   tec_inc;
    logic [TEC_W:0]   tec_sum;
    logic [REC_W-1:0] rec_base;
    logic [REC_W:0]   rec_inc;
    logic [REC_W:0]   rec_sum;

    assign live = (cur_q.st != ST_BUSOFF);

    fcec_dom_run #(
        .FIRST_ACT (ACT_RUN),
        .FIRST_PAS (PAS_RUN),
        .REPEAT    (RPT_RUN)
    ) u_dom_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!live),
        .bit_stb (post_bit_i && live),
        .bit_dom (post_dom_i),
        .ctx_pas (post_pas_ctx_i),
        .penalty (dom_pen)
    );

    fcec_recovery #(
        .BITS (RCV_BITS),
        .RUNS (RCV_RUNS)
    ) u_recovery (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (!live),
        .bit_stb (bus_bit_i),
        .bit_rec (bus_rec_i),
        .done    (recov_done)
    );

    always_comb begin
        // Transmit side: decrement first, then weighted penalties.
        tx_flag_counts = tx_flag_i && !exc_arb_stuff_i &&
                         !(exc_ack_i && (cur_q.st == ST_PASSIVE));
        tec_base = cur_q.tec;
        if (tx_done_i && (cur_q.tec != '0)) tec_base = cur_q.tec - 1'b1;
        tec_inc = (tx_flag_counts              ? T_PEN : '0)
                + ((flag_bit_err_i && is_tx_i) ? T_PEN : '0)
                + ((dom_pen && is_tx_i)        ? T_PEN : '0);
        tec_sum = {1'b0, tec_base} + tec_inc;
        if (tec_sum > T_MAX) tec_sum = T_MAX;

        // Receive side: clean-reception adjust, then penalties, ceiling.
        rec_base = cur_q.rec;
        if (rx_done_i) begin
            if (cur_q.rec == '0)         rec_base = '0;
            else if (cur_q.rec <= R_TOP) rec_base = cur_q.rec - 1'b1;
            else                         rec_base = R_RELOAD;
        end
        rec_inc = ((rx_err_i && !rx_err_flag_bit_i) ? R_ONE : '0)
                + (first_dom_i                      ? R_PEN : '0)
                + ((flag_bit_err_i && !is_tx_i)     ? R_PEN : '0)
                + ((dom_pen && !is_tx_i)            ? R_PEN : '0);
        rec_sum = {1'b0, rec_base} + rec_inc;
        if (rec_sum > R_CEIL) rec_sum = R_CEIL;

        nxt_d = cur_q;
        if (!live) begin
            if (recov_done) begin
                nxt_d.tec = '0;
                nxt_d.rec = '0;
                nxt_d.st  = ST_ACTIVE;
            end
        end else begin
            nxt_d.tec = tec_sum[TEC_W-1:0];
            nxt_d.rec = rec_sum[REC_W-1:0];
            if (nxt_d.tec >= T_BOFF)
                nxt_d.st = ST_BUSOFF;
            else if ((nxt_d.tec >= T_PASS) || (nxt_d.rec >= R_PASS))
                nxt_d.st = ST_PASSIVE;
            else
                nxt_d.st = ST_ACTIVE;
        end
        nxt_d.warn = (nxt_d.tec >= T_WARN) || (nxt_d.rec >= R_WARN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.tec  <= '0;
            cur_q.rec  <= '0;
            cur_q.st   <= ST_ACTIVE;
            cur_q.warn <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign tec_o   = cur_q.tec;
    assign rec_o   = cur_q.rec;
    assign state_o = cur_q.st;
    assign warn_o  = cur_q.warn;
endmodule

// File: rtl/fcec_checker.sv
`timescale 1ns/1ps
module fcec_checker
    import fcec_pkg::*;
#(
    parameter int TEC_W    = 9,
    parameter int REC_W    = 8,
    parameter int PASS_LVL = 128,
    parameter int BOFF_LVL = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TEC_W-1:0] tec,
    input logic [REC_W-1:0] rec,
    input logic [1:0]       st
);
    localparam logic [TEC_W-1:0] T_PASS = TEC_W'(PASS_LVL);
    localparam logic [TEC_W-1:0] T_BOFF = TEC_W'(BOFF_LVL);
    localparam logic [REC_W-1:0] R_PASS = REC_W'(PASS_LVL);

    // R1
    active_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACTIVE) |-> ((tec < T_PASS) && (rec < R_PASS)));

    // R1
    passive_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PASSIVE) |-> ((tec >= T_PASS) || (rec >= R_PASS)));

    // R10
    busoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tec >= T_BOFF) |-> (st == ST_BUSOFF));

    // R8
    rec_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec <= R_PASS);

    // R11
    busoff_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSOFF) |=> (((st == ST_BUSOFF) && $stable(tec) && $stable(rec)) ||
                               ((st == ST_ACTIVE) && (tec == '0) && (rec == '0))));
endmodule

bind fault_conf_counter fcec_checker #(
    .TEC_W    (TEC_W),
    .REC_W    (REC_W),
    .PASS_LVL (PASS_LVL),
    .BOFF_LVL (BOFF_LVL)
) u_fcec_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .tec   (tec_o),
    .rec   (rec_o),
    .st    (state_o)
);

// File: tb/test_fault_conf_counter.sv
`timescale 1ns/1ps
module test_fault_conf_counter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic is_tx, rx_err, rx_err_fb, tx_flag, exc_ack, exc_arb, flag_be;
    logic first_dom, post_bit, post_dom, post_pas, tx_done, rx_done;
    logic bus_bit, bus_rec;
    logic [8:0] tec;
    logic [7:0] rec;
    logic [1:0] st;
    logic       warn;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct {
        string      tag;
        logic [8:0] tec;
        logic [7:0] rec;
        logic [1:0] st;
        logic       warn;
    } exp_t;

    exp_t exp_q[$];
    exp_t it;

    always #4 clk = ~clk;

    fault_conf_counter i_fault_conf_counter (
        .clk(clk), .rst_n(rst_n), .is_tx_i(is_tx),
        .rx_err_i(rx_err), .rx_err_flag_bit_i(rx_err_fb), .tx_flag_i(tx_flag),
        .exc_ack_i(exc_ack), .exc_arb_stuff_i(exc_arb), .flag_bit_err_i(flag_be),
        .first_dom_i(first_dom), .post_bit_i(post_bit), .post_dom_i(post_dom),
        .post_pas_ctx_i(post_pas), .tx_done_i(tx_done), .rx_done_i(rx_done),
        .bus_bit_i(bus_bit), .bus_rec_i(bus_rec),
        .tec_o(tec), .rec_o(rec), .state_o(st), .warn_o(warn)
    );

    task automatic clear_strobes();
        rx_err = 0; rx_err_fb = 0; tx_flag = 0; exc_ack = 0; exc_arb = 0;
        flag_be = 0; first_dom = 0; post_bit = 0; post_dom = 0;
        tx_done = 0; rx_done = 0; bus_bit = 0; bus_rec = 0;
    endtask

    // Driver: strobes are set by the caller at a falling edge; one clock is
    // applied and, when asked, the expected result is queued.
    task automatic cyc(input bit chk, input string tag, input logic [8:0] et,
                       input logic [7:0] er, input logic [1:0] es, input logic ew);
        exp_t e;
        if (chk) begin
            e.tag = tag; e.tec = et; e.rec = er; e.st = es; e.warn = ew;
            exp_q.push_back(e);
        end
        @(negedge clk);
        clear_strobes();
    endtask

    // Monitor: compares after the rising edge has settled.
    always @(posedge clk) begin
        #3;
        if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            checks++;
            if (tec !== it.tec || rec !== it.rec || st !== it.st || warn !== it.warn) begin
                errors++;
                $display("FAIL %s: got tec=%0d rec=%0d st=%0d warn=%0b, expected tec=%0d rec=%0d st=%0d warn=%0b",
                         it.tag, tec, rec, st, warn, it.tec, it.rec, it.st, it.warn);
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        is_tx = 0; post_pas = 0;
        clear_strobes();
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc(1, "R1 reset", 0, 0, 0, 0);

        // R2 receiver error
        rx_err = 1;                cyc(1, "R2 rx error +1", 0, 1, 0, 0);
        rx_err = 1; rx_err_fb = 1; cyc(1, "R2 flag bit error no +1", 0, 1, 0, 0);
        // R4 first dominant after flag
        first_dom = 1;             cyc(1, "R4 first dominant +8", 0, 9, 0, 0);
        // R6 reception decrement and floor
        rx_done = 1;               cyc(1, "R6 rx done -1", 0, 8, 0, 0);
        for (int i = 0; i < 8; i++) begin rx_done = 1; cyc(0, "", 0, 0, 0, 0); end
        rx_done = 1;               cyc(1, "R6 rx done at 0 stays 0", 0, 0, 0, 0);

        // R4 / R5 / R7 transmit side
        is_tx = 1;
        tx_flag = 1;               cyc(1, "R4 tx flag +8", 8, 0, 0, 0);
        tx_flag = 1; exc_arb = 1;  cyc(1, "R5 arbitration stuff exception", 8, 0, 0, 0);
        tx_flag = 1; exc_ack = 1;  cyc(1, "R5 ack qualifier ignored when active", 16, 0, 0, 0);
        tx_done = 1;               cyc(1, "R7 tx done -1", 15, 0, 0, 0);

        // R3 dominant runs, active flag context
        for (int i = 0; i < 12; i++) begin post_bit = 1; post_dom = 1; cyc(0, "", 0, 0, 0, 0); end
        post_bit = 1; post_dom = 1; cyc(1, "R3 13th dominant no penalty", 15, 0, 0, 0);
        post_bit = 1; post_dom = 1; cyc(1, "R3 14th dominant penalty", 23, 0, 0, 0);
        for (int i = 0; i < 6; i++) begin post_bit = 1; post_dom = 1; cyc(0, "", 0, 0, 0, 0); end
        post_bit = 1; post_dom = 1; cyc(1, "R3 7 more no penalty", 23, 0, 0, 0);
        post_bit = 1; post_dom = 1; cyc(1, "R3 8 more penalty", 31, 0, 0, 0);
        post_bit = 1; post_dom = 0; cyc(1, "R3 recessive ends run", 31, 0, 0, 0);
        // R3 passive flag context
        post_pas = 1;
        for (int i = 0; i < 6; i++) begin post_bit = 1; post_dom = 1; cyc(0, "", 0, 0, 0, 0); end
        post_bit = 1; post_dom = 1; cyc(1, "R3 passive 7th no penalty", 31, 0, 0, 0);
        post_bit = 1; post_dom = 1; cyc(1, "R3 passive 8th penalty", 39, 0, 0, 0);
        post_pas = 0;

        // R9 warning edge
        for (int i = 0; i < 7; i++) begin tx_flag = 1; cyc(0, "", 0, 0, 0, 0); end
        cyc(1, "R9 warning low at 95", 95, 0, 0, 0);
        tx_flag = 1;               cyc(1, "R9 warning high at 103", 103, 0, 0, 1);
        // R1 passive edge
        for (int i = 0; i < 2; i++) begin tx_flag = 1; cyc(0, "", 0, 0, 0, 0); end
        tx_flag = 1;               cyc(1, "R1 active at 127", 127, 0, 0, 1);
        tx_flag = 1;               cyc(1, "R1 passive at 135", 135, 0, 1, 1);
        tx_flag = 1; exc_ack = 1;  cyc(1, "R5 ack exception when passive", 135, 0, 1, 1);
        for (int i = 0; i < 7; i++) begin tx_done = 1; cyc(0, "", 0, 0, 0, 0); end
        tx_done = 1;               cyc(1, "R1 back to active", 127, 0, 0, 1);

        // R8 receive ceiling, R6 reload
        is_tx = 0;
        for (int i = 0; i < 15; i++) begin first_dom = 1; cyc(0, "", 0, 0, 0, 0); end
        first_dom = 1;             cyc(1, "R1 passive on receive 128", 127, 128, 1, 1);
        first_dom = 1;             cyc(1, "R8 receive ceiling", 127, 128, 1, 1);
        rx_done = 1;               cyc(1, "R6 reload above 127", 127, 127, 0, 1);
        flag_be = 1;               cyc(1, "R4 flag bit error receiver", 127, 128, 1, 1);
        is_tx = 1;
        flag_be = 1;               cyc(1, "R4 flag bit error transmitter", 135, 128, 1, 1);
        rx_done = 1;               cyc(1, "R6 reload keeps passive via tec", 135, 127, 1, 1);
        for (int i = 0; i < 8; i++) begin tx_done = 1; cyc(0, "", 0, 0, 0, 0); end

        // R10 bus off
        for (int i = 0; i < 15; i++) begin tx_flag = 1; cyc(0, "", 0, 0, 0, 0); end
        tx_flag = 1;               cyc(1, "R10 passive at 255", 255, 127, 1, 1);
        tx_flag = 1;               cyc(1, "R10 bus off at 263", 263, 127, 2, 1);
        tx_flag = 1; rx_err = 1;   cyc(1, "R10 flag and error ignored", 263, 127, 2, 1);
        tx_done = 1; rx_done = 1;  cyc(1, "R10 successes ignored", 263, 127, 2, 1);
        post_bit = 1; post_dom = 1; flag_be = 1; first_dom = 1;
                                   cyc(1, "R10 penalties ignored", 263, 127, 2, 1);

        // R11 recovery
        for (int i = 0; i < 10; i++) begin bus_bit = 1; bus_rec = 1; cyc(0, "", 0, 0, 0, 0); end
        bus_bit = 1; bus_rec = 0;  cyc(1, "R11 dominant restarts run", 263, 127, 2, 1);
        for (int r = 0; r < 127; r++)
            for (int i = 0; i < 11; i++) begin bus_bit = 1; bus_rec = 1; cyc(0, "", 0, 0, 0, 0); end
        for (int i = 0; i < 9; i++) begin bus_bit = 1; bus_rec = 1; cyc(0, "", 0, 0, 0, 0); end
        bus_bit = 1; bus_rec = 1;  cyc(1, "R11 one bit short", 263, 127, 2, 1);
        bus_bit = 1; bus_rec = 1;  cyc(1, "R11 recovered", 0, 0, 0, 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule